// File: doc/BRIEF.md
# Cascaded BCD Time-of-Day Counter

This block keeps the time of day as six binary-coded decimal digits: seconds, minutes and hours, each split into units and tens. A prescaler counts system clock cycles and makes a one-cycle advance pulse once per second. The pulse enters the seconds-units digit. Each digit counts in plain binary and wraps at its own modulus. When a digit wraps, it passes an advance to the next digit in the same clock cycle. The hours pair wraps from 23 to 00, and the chain marks that midnight step with a one-cycle pulse.

When the fast-set input is held, the prescaler period is divided by a speed-up factor of 2000, so an operator can move the displayed time forward quickly. The output gives every digit as its raw 4-bit value, ready to drive one LED per bit. All state sits in one clock domain. Every register uses a synchronous clear and a one-cycle enable. No digit is clocked from another digit. The block has no streaming data path: every pin is a plain control or status signal, so no valid/ready handshake applies.

Top module: `bclk_time_chain`

## Requirements
- R1: While `rst` is high on a rising clock edge, every digit is cleared, so `time_bcd` reads 0x000000 after that edge.
- R2: With `fast_set` low, the time advances by exactly one second once every CLK_HZ clock cycles, counted from the end of reset or from a mode change out of fast-set.
- R3: With `fast_set` high, the time advances once every max(CLK_HZ/2000, 1) cycles. The result is rounded down and is never below one cycle.
- R4: Seconds units counts 0 to 9. On the advance that would make it 10, it clears, and seconds tens advances on that same edge (00:00:09 becomes 00:00:10 in one step).
- R5: Seconds tens counts modulo 6 and advances minutes units on the same edge when it wraps (00:00:59 becomes 00:01:00).
- R6: Minutes units counts modulo 10 and minutes tens counts modulo 6. Both carry on the same edge, so 00:59:59 becomes 01:00:00 in one step.
- R7: Hours units counts modulo 10 while hours tens is below 2, so 09:59:59 becomes 10:00:00.
- R8: From 23:59:59, the next advance gives 00:00:00. `day_wrap` is high in exactly the cycle whose rising edge performs this step, and it is low at all other times.
- R9: `time_bcd` packs the digits as 4-bit fields: [3:0] seconds units, [7:4] seconds tens, [11:8] minutes units, [15:12] minutes tens, [19:16] hours units, [23:20] hours tens.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, CLK_HZ cycles per second |
| rst | input | 1 | Active-high synchronous reset |
| fast_set | input | 1 | Level; high selects the accelerated advance rate |
| time_bcd | output | 24 | Six BCD digits, seconds units in the lowest nibble |
| day_wrap | output | 1 | High in the cycle whose edge turns 23:59:59 into 00:00:00 |

## Verification
The main pattern runs fast-set with a prescaler period of one cycle. It walks the time through a set of targets, and each target is placed on one carry boundary. Seconds units, seconds tens, the minute pair, hours units below 20, and the midnight wrap are each reached alone. A carry that arrives one cycle late or early, or a modulus off by one, changes the value seen at exactly one of these targets. A second pattern leaves fast-set low and samples one cycle before and one cycle after the expected second boundary. This separates a correct prescaler period from one that is one cycle short or long. A reset in the middle of the run, with the time not at zero, shows that the clear overrides counting.

// File: rtl/bclk_pkg.sv
package bclk_pkg;

  localparam int unsigned DIGIT_W  = 4;
  localparam int unsigned N_DIGITS = 6;
  localparam int unsigned N_LOW    = 4;  // seconds and minutes digits

  // Modulus of each low digit: even index = units (10), odd index = tens (6).
  function automatic int unsigned low_mod(input int unsigned idx);
    return (idx % 2 == 0) ? 10 : 6;
  endfunction

endpackage

// File: rtl/bclk_prescaler.sv
module bclk_prescaler #(
  parameter int unsigned CLK_HZ  = 12_000_000,
  parameter int unsigned SPEEDUP = 2000
) (
  input  logic clk,
  input  logic rst,
  input  logic fast_set,
  output logic tick
);

  localparam int unsigned FAST_RAW = CLK_HZ / SPEEDUP;
  localparam int unsigned FAST_LIM = (FAST_RAW < 1) ? 1 : FAST_RAW;
  localparam int unsigned CW       = $clog2(CLK_HZ + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] last;

  always_comb begin
    last = fast_set ? CW'(FAST_LIM - 1) : CW'(CLK_HZ - 1);
    // ">=" so that entering fast mode with a large count ticks at once
    tick = (cnt >= last);
  end

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + CW'(1);
  end

  a_r2_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt < CW'(CLK_HZ));

  a_r3_fast_bound: assert property (@(posedge clk) disable iff (rst)
    fast_set && $past(fast_set) && !$past(rst) |-> cnt < CW'(FAST_LIM));

endmodule

// File: rtl/bclk_digit.sv
module bclk_digit #(
  parameter int unsigned MOD = 10,
  parameter int unsigned W   = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv_i,
  output logic [W-1:0] q_o,
  output logic         carry_o
);

  logic [W-1:0] q;
  logic         at_top;

  assign at_top  = (q == W'(MOD - 1));
  assign carry_o = adv_i && at_top;
  assign q_o     = q;

  always_ff @(posedge clk) begin
    if (rst)           q <= '0;
    else if (carry_o)  q <= '0;
    else if (adv_i)    q <= q + W'(1);
  end

  a_r4_range: assert property (@(posedge clk) disable iff (rst)
    q <= W'(MOD - 1));

  a_r4_wrap_clears: assert property (@(posedge clk) disable iff (rst)
    adv_i && q == W'(MOD - 1) |=> q == '0);

  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    !adv_i |=> $stable(q));

endmodule

// File: rtl/bclk_hours.sv
module bclk_hours #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv_i,
  output logic [W-1:0] units_o,
  output logic [W-1:0] tens_o,
  output logic         wrap_o
);

  logic [W-1:0] units, tens;
  logic         at_23, units_wrap;

  assign at_23      = (tens == W'(2)) && (units == W'(3));
  assign units_wrap = adv_i && (units == W'(9));
  assign wrap_o     = adv_i && at_23;
  assign units_o    = units;
  assign tens_o     = tens;

  always_ff @(posedge clk) begin
    if (rst) begin
      units <= '0;
      tens  <= '0;
    end else if (wrap_o) begin
      units <= '0;
      tens  <= '0;
    end else if (units_wrap) begin
      units <= '0;
      tens  <= tens + W'(1);
    end else if (adv_i) begin
      units <= units + W'(1);
    end
  end

  a_r8_max_23: assert property (@(posedge clk) disable iff (rst)
    (tens < W'(2) && units <= W'(9)) || (tens == W'(2) && units <= W'(3)));

  a_r8_midnight: assert property (@(posedge clk) disable iff (rst)
    adv_i && at_23 |=> units == '0 && tens == '0);

  a_r7_units_carry: assert property (@(posedge clk) disable iff (rst)
    adv_i && units == W'(9) |=> tens == $past(tens) + W'(1));

endmodule

// File: rtl/bclk_time_chain.sv
module bclk_time_chain #(
  parameter int unsigned CLK_HZ  = 12_000_000,
  parameter int unsigned SPEEDUP = 2000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        fast_set,
  output logic [23:0] time_bcd,
  output logic        day_wrap
);

  import bclk_pkg::*;

  logic                 tick;
  logic [N_LOW:0]       adv;
  logic [DIGIT_W-1:0]   low_q [N_LOW];
  logic [DIGIT_W-1:0]   hr_u, hr_t;

  bclk_prescaler #(.CLK_HZ(CLK_HZ), .SPEEDUP(SPEEDUP)) u_pre (
    .clk      (clk),
    .rst      (rst),
    .fast_set (fast_set),
    .tick     (tick)
  );

  assign adv[0] = tick;

  for (genvar i = 0; i < N_LOW; i++) begin : g_low
    bclk_digit #(.MOD(low_mod(i)), .W(DIGIT_W)) u_dig (
      .clk     (clk),
      .rst     (rst),
      .adv_i   (adv[i]),
      .q_o     (low_q[i]),
      .carry_o (adv[i+1])
    );
    assign time_bcd[i*DIGIT_W +: DIGIT_W] = low_q[i];
  end

  bclk_hours #(.W(DIGIT_W)) u_hrs (
    .clk     (clk),
    .rst     (rst),
    .adv_i   (adv[N_LOW]),
    .units_o (hr_u),
    .tens_o  (hr_t),
    .wrap_o  (day_wrap)
  );

  assign time_bcd[N_LOW*DIGIT_W +: DIGIT_W]     = hr_u;
  assign time_bcd[(N_LOW+1)*DIGIT_W +: DIGIT_W] = hr_t;

  // Same-edge carry: seconds wrapping from 59 must move minutes on that edge.
  a_r5_min_same_edge: assert property (@(posedge clk) disable iff (rst)
    tick && time_bcd[7:0] == 8'h59 |=> time_bcd[7:0] == 8'h00 &&
      time_bcd[11:8] != $past(time_bcd[11:8]));

  a_r6_hour_same_edge: assert property (@(posedge clk) disable iff (rst)
    tick && time_bcd[15:0] == 16'h5959 |=> time_bcd[15:0] == 16'h0000 &&
      time_bcd[23:16] != $past(time_bcd[23:16]));

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> time_bcd == 24'h0);

endmodule

// File: tb/bclk_time_chain_tb.sv
`timescale 1ns/1ps
module bclk_time_chain_tb;

  localparam int unsigned CLK_HZ = 2000;  // fast period = 2000/2000 = 1 cycle
  localparam int N_VEC = 11;

  // cumulative seconds since reset, expected time, expected day_wrap
  localparam int          TGT  [N_VEC] = '{1, 9, 10, 59, 60, 3599, 3600,
                                           35999, 36000, 86399, 86400};
  localparam logic [23:0] EXPT [N_VEC] = '{24'h000001, 24'h000009, 24'h000010,
                                           24'h000059, 24'h000100, 24'h005959,
                                           24'h010000, 24'h095959, 24'h100000,
                                           24'h235959, 24'h000000};
  localparam logic        EXPW [N_VEC] = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fast_set = 1'b0;
  logic [23:0] time_bcd;
  logic        day_wrap;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  bclk_time_chain #(.CLK_HZ(CLK_HZ)) u_dut (
    .clk      (clk),
    .rst      (rst),
    .fast_set (fast_set),
    .time_bcd (time_bcd),
    .day_wrap (day_wrap)
  );

  task automatic check(input string req, input logic [23:0] act,
                       input logic [23:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(input int n);
    for (int k = 0; k < n; k++) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    int secs;
    run(3);
    check("R1 reset", time_bcd, 24'h0);
    check("R8 no wrap in reset", {23'h0, day_wrap}, 24'h0);

    rst = 1'b0;
    fast_set = 1'b1;
    secs = 0;
    // R3 R4 R5 R6 R7 R8 R9: walk carry boundaries in fast-set mode
    for (int i = 0; i < N_VEC; i++) begin
      run(TGT[i] - secs);
      secs = TGT[i];
      check($sformatf("R3-walk R9 t=%0d", TGT[i]), time_bcd, EXPT[i]);
      check($sformatf("R8 day_wrap t=%0d", TGT[i]), {23'h0, day_wrap},
            {23'h0, EXPW[i]});
    end

    // R2: normal rate, one second per CLK_HZ cycles
    fast_set = 1'b0;
    run(CLK_HZ - 1);
    check("R2 before boundary", time_bcd, 24'h000000);
    run(1);
    check("R2 at boundary", time_bcd, 24'h000001);
    run(CLK_HZ);
    check("R2 second period", time_bcd, 24'h000002);

    // R1: reset in mid-count
    rst = 1'b1;
    run(1);
    check("R1 mid-run reset", time_bcd, 24'h0);

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 150000; k++) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule